// File: doc/BRIEF.md
# Block Floating-Point Scaling Pipeline

This block gives a whole block of streamed fixed-point elements one shared scale. Elements arrive one per cycle, qualified by a valid flag, and the final element of each block carries a last tag. For every accepted element the block counts how many zero bits lead it from the most significant end. It keeps the smallest such count seen in the current block, so that the element with the largest magnitude can still be shifted without overflow.

The caller presents the same data a second time. While it does so, the count measured on the previous pass is applied as one common left shift to every element, and the vacated low bits are filled with zeros. Measuring and applying overlap: the shift that a block measures takes effect from the first element after that block's last element. No element storage is held inside the block.

A two-state controller marks whether a complete block has been measured yet. `ST_COLD` is the state after reset, and the applied shift is zero in it. On the first accepted element tagged last, the transition `COLD_TO_WARM` leads to `ST_WARM`. In `ST_WARM` every later last element reloads the applied shift, through the self-transition `WARM_RELOAD`. Reset returns the controller to `ST_COLD` from either state. One register stage separates input from output. Each output element is reported together with the shift that was applied to it.

Top module: `bfp_scale_pipe`

## Requirements
- R1: While reset is asserted, `out_valid`, `out_last`, `out_data` and `out_shift` are all zero.
- R2: After reset, until the output stage has delivered an element tagged last, every element is passed through unshifted and `out_shift` is 0.
- R3: `out_valid` and `out_last` equal `in_valid` and `in_last` of the previous clock cycle.
- R4: `out_data` equals the previous cycle's `in_data` shifted left by `out_shift`. Bit DATA_W-1 is the most significant bit, bits shifted out at the top are lost, and vacated low bits are zero.
- R5: The count of an element is the number of zero bits above its highest set bit. An all-zero element counts as DATA_W-1.
- R6: The shift measured for a block is the minimum count over all of its accepted elements, the last element included. It is applied from the first element accepted after that last element.
- R7: Measurement restarts at DATA_W-1 for each block and after reset, so a block's shift does not depend on elements of any earlier block.
- R8: `out_shift` is the shift applied to that output element. It changes only between an output element tagged last and the next output element.
- R9: Cycles with `in_valid` low are ignored. They produce `out_valid` low, take no part in measurement, and leave `out_shift` unchanged.
- R10: A block of a single element is measured from that element alone, and its count becomes the next applied shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Element present on `in_data` this cycle |
| in_last | input | 1 | Element is the final one of its block |
| in_data | input | DATA_W (32) | Unsigned element |
| out_valid | output | 1 | Scaled element present |
| out_last | output | 1 | Scaled element closes its block |
| out_data | output | DATA_W (32) | Element shifted left by `out_shift` |
| out_shift | output | CNT_W (5) | Shift applied to this element |

## Verification
The bench builds the block with its default DATA_W of 32, so CNT_W is 5. With this width the full shift range from 0 to 31 can be reached. The largest shift, 31, comes from a block that holds only zero or single-lsb elements, and the applied shift of 31 moves all but one bit out of the top of the word. The stimulus also covers a single-element block whose count is 0, a run of one-element blocks that swing the shift from 12 to 0 to 31, gaps in the valid stream, and a reset in the middle of a block that discards a partly measured minimum.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

    // Controller states: COLD until a full block has been measured.
    typedef enum logic {
        ST_COLD = 1'b0,
        ST_WARM = 1'b1
    } bfp_state_e;

endpackage

// File: rtl/bfp_lead_count.sv
// Counts zero bits above the highest set bit; all-zero gives DATA_W-1 (R5).
module bfp_lead_count #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  count
);

    always_comb begin
        count = CNT_W'(DATA_W - 1);
        for (int i = 0; i < DATA_W; i++) begin
            if (data[i]) begin
                count = CNT_W'(DATA_W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/bfp_left_shift.sv
// Logarithmic left shifter with zero fill, one stage per shift-amount bit.
module bfp_left_shift #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  amount,
    output logic [DATA_W-1:0] data_out
);

    logic [DATA_W-1:0] stage [0:CNT_W];

    assign stage[0] = data_in;

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amount[k]
                          ? {stage[k][DATA_W-1-STEP:0], {STEP{1'b0}}}
                          : stage[k];
    end

    assign data_out = stage[CNT_W];

endmodule

// File: rtl/bfp_min_track.sv
// Holds the running minimum count of the current block and the shift
// to be applied; hands the minimum over on a last element (R6, R7).
module bfp_min_track #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             close,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] next_shift
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] run_min_q;
    logic [CNT_W-1:0] merged;
    logic [CNT_W-1:0] shift_q;

    assign merged     = (count < run_min_q) ? count : run_min_q;
    assign next_shift = shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_min_q <= CNT_MAX;
            shift_q   <= '0;
        end else if (take) begin
            if (close) begin
                run_min_q <= CNT_MAX;
                shift_q   <= merged;
            end else begin
                run_min_q <= merged;
            end
        end
    end

endmodule

// File: rtl/bfp_scale_pipe.sv
module bfp_scale_pipe #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data,
    output logic [CNT_W-1:0]  out_shift
);

    import bfp_pkg::*;

    bfp_state_e       state_q;
    bfp_state_e       state_d;
    logic             close_blk;
    logic [CNT_W-1:0] elem_cnt;
    logic [CNT_W-1:0] stored_shift;
    logic [CNT_W-1:0] apply_shift;
    logic [DATA_W-1:0] shifted;

    assign close_blk = in_valid && in_last;

    bfp_lead_count #(.DATA_W(DATA_W)) u_count (
        .data  (in_data),
        .count (elem_cnt)
    );

    bfp_min_track #(.DATA_W(DATA_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (in_valid),
        .close      (in_last),
        .count      (elem_cnt),
        .next_shift (stored_shift)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: COLD_TO_WARM on the first closing element,
    // WARM_RELOAD on every later one (shift reload in the tracker).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLD: if (close_blk) state_d = ST_WARM;
            ST_WARM: state_d = ST_WARM;
            default: state_d = ST_COLD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_COLD: apply_shift = '0;
            ST_WARM: apply_shift = stored_shift;
            default: apply_shift = '0;
        endcase
    end

    bfp_left_shift #(.DATA_W(DATA_W)) u_shift (
        .data_in  (in_data),
        .amount   (apply_shift),
        .data_out (shifted)
    );

    // Output stage: one register from input to output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            out_shift <= '0;
        end else begin
            out_valid <= in_valid;
            out_last  <= in_valid && in_last;
            if (in_valid) begin
                out_data  <= shifted;
                out_shift <= apply_shift;
            end
        end
    end

endmodule

// File: rtl/bfp_scale_pipe_chk.sv
module bfp_scale_pipe_chk #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_last,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_last,
    input logic [DATA_W-1:0] out_data,
    input logic [CNT_W-1:0]  out_shift
);

    logic              seen_last_q;
    logic              have_prev_q;
    logic              prev_last_q;
    logic [CNT_W-1:0]  prev_shift_q;
    logic [DATA_W-1:0] low_mask;

    assign low_mask = ({{(DATA_W-1){1'b0}}, 1'b1} << out_shift) - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_last_q  <= 1'b0;
            have_prev_q  <= 1'b0;
            prev_last_q  <= 1'b0;
            prev_shift_q <= '0;
        end else if (out_valid) begin
            seen_last_q  <= seen_last_q || out_last;
            have_prev_q  <= 1'b1;
            prev_last_q  <= out_last;
            prev_shift_q <= out_shift;
        end
    end

    assert_valid_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_shift)));

    assert_last_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_last == $past(in_last)));

    assert_shifted_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data == ($past(in_data) << out_shift)));

    assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & low_mask) == '0));

    assert_cold_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seen_last_q) |-> (out_shift == '0));

    assert_block_constant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && have_prev_q && !prev_last_q) |-> (out_shift == prev_shift_q));

endmodule

bind bfp_scale_pipe bfp_scale_pipe_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_data  (out_data),
    .out_shift (out_shift)
);

// File: tb/bfp_scale_pipe_tb.sv
module bfp_scale_pipe_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 5;
    localparam int NVEC       = 15;

    // {valid, last, data, expected applied shift}
    localparam logic [38:0] VEC [0:NVEC-1] = '{
        {1'b1, 1'b0, 32'h0000_1234, 5'd0 },  // 0  cold, cnt 19
        {1'b1, 1'b0, 32'h0010_0000, 5'd0 },  // 1  cnt 11
        {1'b0, 1'b0, 32'hDEAD_BEEF, 5'd0 },  // 2  gap
        {1'b1, 1'b1, 32'h0000_0001, 5'd0 },  // 3  last, cnt 31 -> min 11
        {1'b1, 1'b0, 32'h0008_0000, 5'd11},  // 4  cnt 12
        {1'b1, 1'b0, 32'h0000_0000, 5'd11},  // 5  zero, cnt 31
        {1'b1, 1'b1, 32'h0000_00FF, 5'd11},  // 6  cnt 24 -> min 12
        {1'b1, 1'b1, 32'h8000_0000, 5'd12},  // 7  single, cnt 0
        {1'b1, 1'b1, 32'h0000_0000, 5'd0 },  // 8  single, cnt 31
        {1'b1, 1'b0, 32'h0000_0003, 5'd31},  // 9  cnt 30
        {1'b0, 1'b1, 32'h0000_0007, 5'd31},  // 10 gap with last high
        {1'b1, 1'b1, 32'h4000_0000, 5'd31},  // 11 cnt 1 -> min 1
        {1'b1, 1'b0, 32'hFFFF_FFFF, 5'd1 },  // 12 cnt 0
        {1'b1, 1'b1, 32'h0000_0001, 5'd1 },  // 13
        {1'b0, 1'b0, 32'h0000_0000, 5'd1 }   // 14 idle
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_last = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_last;
    logic [DATA_W-1:0] out_data;
    logic [CNT_W-1:0]  out_shift;

    int  n_checks = 0;
    int  n_bad    = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfp_scale_pipe #(.DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_data  (out_data),
        .out_shift (out_shift)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            2, 10, 14: return "R9 gap";
            3:         return "R5 zero-above-lsb";
            4, 5, 6:   return "R6 block min";
            7:         return "R10 single element";
            8:         return "R6 count 0 applied";
            9, 11:     return "R7 restart at max";
            12, 13:    return "R6 min after restart";
            default:   return "R2 cold pass";
        endcase
    endfunction

    task automatic drive(input logic v, input logic l, input logic [DATA_W-1:0] d);
        in_valid = v;
        in_last  = l;
        in_data  = d;
    endtask

    task automatic check_elem(input string req, input logic l,
                              input logic [DATA_W-1:0] d, input logic [CNT_W-1:0] sh);
        check({req, " R3 valid"}, 32'(out_valid), 32'd1);
        check({req, " R3 last"},  32'(out_last),  32'(l));
        check({req, " R8 shift"}, 32'(out_shift), 32'(sh));
        check({req, " R4 data"},  out_data,       d << sh);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 last",  32'(out_last),  32'd0);
        check("R1 data",  out_data,       32'd0);
        check("R1 shift", 32'(out_shift), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i <= NVEC; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (VEC[i-1][38]) begin
                    check_elem(tag_of(i-1), VEC[i-1][37], VEC[i-1][36:5], VEC[i-1][4:0]);
                end else begin
                    check({tag_of(i-1), " valid"}, 32'(out_valid), 32'd0);
                    check({tag_of(i-1), " shift"}, 32'(out_shift), 32'(VEC[i-1][4:0]));
                end
            end
            if (i < NVEC) drive(VEC[i][38], VEC[i][37], VEC[i][36:5]);
            else          drive(1'b0, 1'b0, '0);
        end

        // Block of one lsb element -> shift 31 for the next element
        drive(1'b1, 1'b1, 32'h0000_0001);
        @(negedge clk);
        check_elem("R10 lsb block", 1'b1, 32'h0000_0001, 5'd0);
        drive(1'b1, 1'b0, 32'h0000_0005);
        @(negedge clk);
        check_elem("R4 top bits lost", 1'b0, 32'h0000_0005, 5'd31);
        drive(1'b0, 1'b0, '0);

        // Reset in mid-block
        rst_n = 1'b0;
        #1;
        check("R1 valid mid", 32'(out_valid), 32'd0);
        check("R1 data mid",  out_data,       32'd0);
        check("R1 shift mid", 32'(out_shift), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, 32'h0000_0005);
        @(negedge clk);
        check_elem("R2 cold after reset", 1'b1, 32'h0000_0005, 5'd0);
        // Partial minimum before reset discarded: new shift from 0x5 alone is 29
        drive(1'b1, 1'b1, 32'h0000_0001);
        @(negedge clk);
        check_elem("R7 reset clears tracker", 1'b1, 32'h0000_0001, 5'd29);
        drive(1'b0, 1'b0, '0);
        @(negedge clk);
        check("R9 idle end", 32'(out_valid), 32'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule